// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block keeps the status byte of a serial-interface memory and decides whether a write may go ahead. The serial front-end hands it single-cycle command strobes (set write enable, clear write enable, write status with a data byte), the chip-select level, and the write-protect pin. The write engine hands it a busy flag. In return the block presents the status byte for reads, flags whether the address currently on its input lies in a protected region, and says whether a memory write to that address is permitted.

A status write is not applied when its strobe arrives. It is held pending and committed only when chip select is released. If the protect pin goes low while the write is pending, and the protect-pin enable bit is set, the write is cancelled. Three block-protect bits choose one of the following protected regions: none, one quarter of the array, the lower half, the first page or the last page.

Top module: `status_guard`

## Requirements
- R1: After reset the status byte reads 0x00 and `wr_ok` is 0.
- R2: The status byte has this layout: bit 7 is the protect-pin enable (PE), bits 6 and 5 always read 0, bits 4:2 hold the protect code BP, bit 1 is the write-enable latch (WE), and bit 0 equals `busy` in the same cycle.
- R3: A `cmd_wren` strobe sets WE at the next clock edge, and a `cmd_wrdi` strobe clears it. While `busy` is 1, both strobes are ignored.
- R4: WE clears at the first clock edge after `busy` falls. At that edge this clear wins over a `cmd_wren` strobe in the same cycle.
- R5: A `cmd_wrsr` strobe is accepted only while `sel_n` is low, `busy` is 0 and WE is 1. When `sel_n` next rises, `wrsr_data[7]` is loaded into PE and `wrsr_data[4:2]` into BP, and `sr_start` pulses for that one cycle. No other status bit can be written.
- R6: While PE is 1 and `wp_n` is low, no status write is accepted or committed. While PE is 0, `wp_n` has no effect.
- R7: If PE is 1 and `wp_n` is low at any clock edge while a status write is pending, that write is dropped, even if `wp_n` returns high before `sel_n` rises.
- R8: BP selects the protected region of a 2^ADDR_W byte array: 0 none; 1, 2, 3 and 4 the first, second, third and fourth quarter; 5 the lower half; 6 the first PAGE_BYTES page; 7 the last page. `prot_hit` is 1 exactly when `addr` lies in the selected region.
- R9: `wr_ok` is 1 exactly when WE is 1 and `prot_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n | input | 1 | Chip select level, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| busy | input | 1 | Internal write cycle in progress |
| cmd_wren | input | 1 | Set-write-enable strobe |
| cmd_wrdi | input | 1 | Clear-write-enable strobe |
| cmd_wrsr | input | 1 | Write-status strobe |
| wrsr_data | input | 8 | Data byte for the status write |
| addr | input | ADDR_W | Byte address to check |
| status_o | output | 8 | Status byte |
| prot_hit | output | 1 | Address is in the protected region |
| wr_ok | output | 1 | Memory write to addr is permitted |
| sr_start | output | 1 | Status write is committed this cycle |

## Verification
A wrong protect code or a wrong region decode shows up on `prot_hit` and `wr_ok` in the same cycle the address is driven. For that reason, every address is swept under each of the eight codes. A stuck or mistimed write-enable latch, or a pending status write that should have been dropped, shows in the status byte one clock edge after the strobe or the deselect. The checks sample there, so a lost cancel or a missed completion clear is caught within one cycle.

// File: rtl/status_guard.sv
module status_guard #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              cmd_wren,
  input  logic              cmd_wrdi,
  input  logic              cmd_wrsr,
  input  logic [7:0]        wrsr_data,
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        status_o,
  output logic              prot_hit,
  output logic              wr_ok,
  output logic              sr_start
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int HI_W   = ADDR_W - PAGE_W;

  logic       pe_q, we_q, sel_q, busy_q, pend_q;
  logic [2:0] bp_q;
  logic [3:0] pend_d;

  wire done  = busy_q & ~busy;
  wire lock  = pe_q & ~wp_n;
  wire rise  = ~sel_q & sel_n;
  wire take  = cmd_wrsr & ~busy & we_q & ~sel_n & ~lock;

  assign sr_start = pend_q & rise & ~lock;
  assign status_o = {pe_q, 2'b00, bp_q, we_q, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_q   <= 1'b0;
      bp_q   <= 3'b000;
      we_q   <= 1'b0;
      sel_q  <= 1'b1;
      busy_q <= 1'b0;
      pend_q <= 1'b0;
      pend_d <= 4'h0;
    end else begin
      sel_q  <= sel_n;
      busy_q <= busy;
      if (done)                  we_q <= 1'b0;
      else if (!busy && cmd_wren) we_q <= 1'b1;
      else if (!busy && cmd_wrdi) we_q <= 1'b0;
      if (rise || lock)          pend_q <= 1'b0;
      else if (take) begin
        pend_q <= 1'b1;
        pend_d <= {wrsr_data[7], wrsr_data[4:2]};
      end
      if (sr_start) {pe_q, bp_q} <= pend_d;
    end
  end

  always_comb begin
    case (bp_q)
      3'd1, 3'd2, 3'd3, 3'd4: prot_hit = (addr[ADDR_W-1 -: 2] == 2'(bp_q - 3'd1));
      3'd5:    prot_hit = ~addr[ADDR_W-1];
      3'd6:    prot_hit = (addr[ADDR_W-1 -: HI_W] == '0);
      3'd7:    prot_hit = &addr[ADDR_W-1 -: HI_W];
      default: prot_hit = 1'b0;
    endcase
  end

  assign wr_ok = we_q & ~prot_hit;

  assert_wren_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wren && !busy && !busy_q) |=> status_o[1]);
  assert_busy_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !status_o[1]) |=> !status_o[1]);
  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> !status_o[1]);
  assert_only_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sr_start |=> $stable(status_o[7:2]));
  assert_pin_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7] && !wp_n) |-> !sr_start);
  assert_permit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |-> status_o[1]);
endmodule

// File: tb/status_guard_tb.sv
module status_guard_tb;
  logic clk = 0, rst_n = 0, sel_n = 1, wp_n = 1, busy = 0;
  logic cmd_wren = 0, cmd_wrdi = 0, cmd_wrsr = 0;
  logic [7:0] wrsr_data = 0;
  logic [12:0] addr = 0;
  logic [7:0] status_o;
  logic prot_hit, wr_ok, sr_start;
  int n_chk = 0, n_bad = 0;

  status_guard #(.ADDR_W(13), .PAGE_BYTES(64)) u_dut (.*);

  always #5 clk = ~clk;

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    cmd_wren = (which == 0); cmd_wrdi = (which == 1); cmd_wrsr = (which == 2);
    @(negedge clk);
    cmd_wren = 0; cmd_wrdi = 0; cmd_wrsr = 0;
  endtask

  task automatic wrsr(input logic [7:0] d, input bit drop_wp);
    @(negedge clk); sel_n = 0;
    wrsr_data = d;
    strobe(2);
    if (drop_wp) begin wp_n = 0; @(negedge clk); wp_n = 1; end
    sel_n = 1;
    @(negedge clk);
  endtask

  function automatic bit exp_prot(input int bp, input int a);
    case (bp)
      1, 2, 3, 4: return (a / 2048) == bp - 1;
      5: return a < 4096;
      6: return a < 64;
      7: return a >= 8128;
      default: return 0;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status_o, 8'h00);
    chk("R1 wr_ok", wr_ok, 0);
    rst_n = 1;
    @(negedge clk);

    strobe(0);
    chk("R3 wren", status_o, 8'h02);
    strobe(1);
    chk("R3 wrdi", status_o, 8'h00);

    wrsr(8'h9C, 0);
    chk("R5 no WE", status_o, 8'h00);

    for (int bp = 0; bp < 8; bp++) begin
      strobe(0);
      wrsr(8'(bp << 2), 0);
      chk("R2 R5 layout", status_o, (bp << 2) | 2);
      for (int a = 0; a < 8192; a++) begin
        addr = 13'(a);
        #1;
        chk("R8 prot", prot_hit, exp_prot(bp, a));
        chk("R9 wr_ok", wr_ok, !exp_prot(bp, a));
      end
    end
    strobe(1);
    addr = 13'h1FFF; #1;
    chk("R9 WE off", wr_ok, 0);

    strobe(0);
    wrsr(8'h63, 0);
    chk("R5 masked bits", status_o, 8'h02);
    wrsr(8'hFF, 0);
    chk("R2 R5 reserved zero", status_o, 8'h9E);

    wp_n = 0;
    wrsr(8'h80, 0);
    chk("R6 locked", status_o, 8'h9E);
    wp_n = 1;
    wrsr(8'h84, 1);
    chk("R7 cancel", status_o, 8'h9E);
    wrsr(8'h00, 0);
    chk("R6 wp high", status_o, 8'h02);
    wp_n = 0;
    wrsr(8'h10, 0);
    chk("R6 PE off", status_o, 8'h12);
    wp_n = 1;

    @(negedge clk); busy = 1; #1;
    chk("R2 ready bit", status_o[0], 1);
    strobe(1);
    chk("R3 busy ignore", status_o[1], 1);
    @(negedge clk); busy = 0; cmd_wren = 1;
    @(negedge clk); cmd_wren = 0;
    chk("R4 done clear", status_o, 8'h10);

    @(negedge clk); sel_n = 0; wrsr_data = 8'h04;
    strobe(2);
    chk("R5 pending", status_o, 8'h10);
    sel_n = 1; #1;
    chk("R5 start pulse", sr_start, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule